// File: doc/BRIEF.md
# System Control Register Bank

This block is a 4 KiB window of 32-bit control words on a simple word-addressed bus. The bus carries a write enable, a read enable, a byte offset, write data and registered read data. The lower half of the window, 512 words, is ordinary read/write storage. Four of these words come out of reset holding fixed identification values, and every other word comes out of reset as zero. Reads of three particular words always return bits 29 and 28 set, whatever is stored there.

The upper half of the window has no storage. Any access there is dropped and flagged on a one-cycle bad-access output. One offset in that upper half, 0xF00, is a power-control doorbell. Writing 1 or 2 there sends a one-cycle system-reset request, and writing 3 sends a one-cycle shutdown request. The surrounding chip logic acts on these pulses. The block does not sequence reset or power itself.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, word 0x40 (byte 0x100) holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121, word 0x43 holds 0x05F40121, and all other words hold zero. During reset all outputs are zero.
- R2: A write with byte offset below 0x800 stores the data at word index offset/4. A read with rd_en presents the word on rdata one cycle later. rdata holds its value in cycles with no read.
- R3: When a read and a write hit the same word in the same cycle, the read returns the value held before the write.
- R4: Reads of byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000. Reads of other offsets, including 0x104, return the stored word unmodified.
- R5: A write of 1 or 2 to byte offset 0xF00 makes sys_reset_req high for exactly the following cycle.
- R6: A write of 3 to byte offset 0xF00 makes shutdown_req high for exactly the following cycle. Any other value written there raises neither request. The two requests are never high together.
- R7: A write with byte offset 0x800 or above, 0xF00 included, changes no stored word and raises bad_access for the following cycle.
- R8: A read with byte offset 0x800 or above returns zero on rdata and raises bad_access for the following cycle.
- R9: Address bits 1:0 are ignored for storage, read forcing and the power decode.
- R10: Requests are raised only by writes. A read of 0xF00 raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset in the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system-reset request |
| shutdown_req | output | 1 | One-cycle shutdown request |
| bad_access | output | 1 | One-cycle out-of-range access flag |

## Verification
Every result appears exactly one clock edge after the access that causes it. This covers rdata, both request pulses and bad_access. A stored word becomes visible to a read issued in the following cycle. The bench drives each access at a falling edge and updates its reference model at the next rising edge. At the falling edge after that, it compares all four outputs, so each comparison falls in the single cycle where the result is due. The bench also runs idle cycles between accesses, which show that the pulses drop after one cycle and that rdata holds.

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 12,
  parameter int DEPTH = 512,
  parameter logic [OFFS_W-1:0] POWER_OFFS = 12'hF00,
  parameter logic [DATA_W-1:0] FORCE_MASK = 32'h3000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [OFFS_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              sys_reset_req,
  output logic              shutdown_req,
  output logic              bad_access
);
  localparam int IDX_W = OFFS_W - 2;
  localparam int MEM_AW = $clog2(DEPTH);
  localparam logic [IDX_W:0] DEPTH_L = (IDX_W+1)'(DEPTH);
  localparam logic [IDX_W-1:0] POWER_IDX = POWER_OFFS[OFFS_W-1:2];

  function automatic logic [DATA_W-1:0] reset_word(input int i);
    case (i)
      'h40: reset_word = DATA_W'(32'h05F2_0121);
      'h41: reset_word = DATA_W'(32'h0000_0002);
      'h42: reset_word = DATA_W'(32'h05F3_0121);
      'h43: reset_word = DATA_W'(32'h05F4_0121);
      default: reset_word = '0;
    endcase
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic [MEM_AW-1:0] widx;
  logic              in_range;
  logic              forced;
  logic              power_hit;
  logic              unused_low;

  assign idx        = addr[OFFS_W-1:2];
  assign widx       = idx[MEM_AW-1:0];
  assign in_range   = {1'b0, idx} < DEPTH_L;
  assign forced     = (idx == IDX_W'('h40)) || (idx == IDX_W'('h42)) || (idx == IDX_W'('h43));
  assign power_hit  = wr_en && (idx == POWER_IDX);
  assign unused_low = ^addr[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= reset_word(i);
    end else if (wr_en && in_range) begin
      mem[widx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata         <= '0;
      sys_reset_req <= 1'b0;
      shutdown_req  <= 1'b0;
      bad_access    <= 1'b0;
    end else begin
      if (rd_en)
        rdata <= in_range ? (mem[widx] | (forced ? FORCE_MASK : '0)) : '0;
      sys_reset_req <= power_hit && (wdata == DATA_W'(1) || wdata == DATA_W'(2));
      shutdown_req  <= power_hit && (wdata == DATA_W'(3));
      bad_access    <= (wr_en || rd_en) && !in_range;
    end
  end
endmodule

module sysctl_regbank_chk #(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 12,
  parameter int DEPTH = 512,
  parameter logic [OFFS_W-1:0] POWER_OFFS = 12'hF00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [OFFS_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              sys_reset_req,
  input logic              shutdown_req,
  input logic              bad_access
);
  logic out_of_range;
  logic at_power;
  assign out_of_range = 32'(addr[OFFS_W-1:2]) >= 32'(DEPTH);
  assign at_power     = addr[OFFS_W-1:2] == POWER_OFFS[OFFS_W-1:2];

  assert_req_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_reset_req && shutdown_req));

  assert_reset_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(wr_en) && $past(at_power) &&
                      ($past(wdata) == DATA_W'(1) || $past(wdata) == DATA_W'(2)));

  assert_shutdown_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(wr_en) && $past(at_power) && $past(wdata) == DATA_W'(3));

  assert_read_only_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !sys_reset_req && !shutdown_req);

  assert_bad_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(wr_en || rd_en) && $past(out_of_range));

  assert_bad_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && out_of_range |=> rdata == '0 && bad_access);

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en && $past(rst_n) |=> $stable(rdata));
endmodule

bind sysctl_regbank sysctl_regbank_chk #(
  .DATA_W(DATA_W), .OFFS_W(OFFS_W), .DEPTH(DEPTH), .POWER_OFFS(POWER_OFFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .sys_reset_req(sys_reset_req),
  .shutdown_req(shutdown_req), .bad_access(bad_access)
);

// File: tb/sysctl_regbank_test.sv
`timescale 1ns/1ps
module sysctl_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sys_reset_req, shutdown_req, bad_access;

  int vectors = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] model [512];
  logic [31:0] exp_rdata = '0;
  logic        exp_rst = 0, exp_shd = 0, exp_bad = 0;

  always #2 clk = ~clk;

  sysctl_regbank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sys_reset_req(sys_reset_req),
    .shutdown_req(shutdown_req), .bad_access(bad_access)
  );

  task automatic model_reset();
    for (int i = 0; i < 512; i++) model[i] = 32'h0;
    model['h40] = 32'h05F2_0121;
    model['h41] = 32'h0000_0002;
    model['h42] = 32'h05F3_0121;
    model['h43] = 32'h05F4_0121;
    exp_rdata = '0; exp_rst = 0; exp_shd = 0; exp_bad = 0;
  endtask

  task automatic model_clock(bit w, bit r, logic [11:0] a, logic [31:0] d);
    int ix = int'(a[11:2]);
    exp_rst = w && ix == 'h3C0 && (d == 1 || d == 2);
    exp_shd = w && ix == 'h3C0 && d == 3;
    exp_bad = (w || r) && ix >= 512;
    if (r) begin
      if (ix >= 512) exp_rdata = 0;
      else begin
        exp_rdata = model[ix];
        if (ix == 'h40 || ix == 'h42 || ix == 'h43) exp_rdata |= 32'h3000_0000;
      end
    end
    if (w && ix < 512) model[ix] = d;
  endtask

  task automatic compare(string tag);
    vectors++;
    if (rdata !== exp_rdata) begin
      errors++; $display("FAIL %s rdata act=%h exp=%h", tag, rdata, exp_rdata);
    end
    if (sys_reset_req !== exp_rst) begin
      errors++; $display("FAIL %s sys_reset_req act=%b exp=%b", tag, sys_reset_req, exp_rst);
    end
    if (shutdown_req !== exp_shd) begin
      errors++; $display("FAIL %s shutdown_req act=%b exp=%b", tag, shutdown_req, exp_shd);
    end
    if (bad_access !== exp_bad) begin
      errors++; $display("FAIL %s bad_access act=%b exp=%b", tag, bad_access, exp_bad);
    end
  endtask

  task automatic step(bit w, bit r, logic [11:0] a, logic [31:0] d, string tag);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(posedge clk);
    model_clock(w, r, a, d);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 12'h0, 32'h0, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;

    step(0, 1, 12'h100, 0, "R1");
    step(0, 1, 12'h104, 0, "R1");
    step(0, 1, 12'h108, 0, "R1");
    step(0, 1, 12'h10C, 0, "R1");
    step(0, 1, 12'h000, 0, "R1");
    step(0, 1, 12'h7FC, 0, "R1");

    step(1, 0, 12'h004, 32'hA5A5_1234, "R2");
    step(0, 1, 12'h004, 0, "R2");
    idle("R2"); idle("R2");
    step(1, 0, 12'h7FC, 32'hDEAD_BEEF, "R2");
    step(0, 1, 12'h7FC, 0, "R2");

    step(1, 0, 12'h008, 32'h1111_1111, "R3");
    step(1, 1, 12'h008, 32'h2222_2222, "R3");
    step(0, 1, 12'h008, 0, "R3");

    step(1, 0, 12'h100, 32'h0, "R4");
    step(0, 1, 12'h100, 0, "R4");
    step(1, 0, 12'h108, 32'hFFFF_0000, "R4");
    step(0, 1, 12'h108, 0, "R4");
    step(1, 0, 12'h104, 32'h0, "R4");
    step(0, 1, 12'h104, 0, "R4");
    step(1, 0, 12'h10C, 32'h3000_0000, "R4");
    step(0, 1, 12'h10C, 0, "R4");
    step(0, 1, 12'h110, 0, "R4");

    step(1, 0, 12'hF00, 32'd1, "R5");
    idle("R5");
    step(1, 0, 12'hF00, 32'd2, "R5");
    step(1, 0, 12'hF00, 32'd1, "R5");
    idle("R5");

    step(1, 0, 12'hF00, 32'd3, "R6");
    idle("R6");
    step(1, 0, 12'hF00, 32'd0, "R6");
    step(1, 0, 12'hF00, 32'd4, "R6");
    step(1, 0, 12'hF00, 32'h1_0001, "R6");
    step(1, 0, 12'hF04, 32'd1, "R6");

    step(1, 0, 12'h800, 32'hCAFE_0001, "R7");
    step(1, 0, 12'hC00, 32'hCAFE_0002, "R7");
    step(0, 1, 12'h000, 0, "R7");
    step(0, 1, 12'h400, 0, "R7");
    step(0, 1, 12'h100, 0, "R7");

    step(0, 1, 12'h800, 0, "R8");
    step(0, 1, 12'hFFC, 0, "R8");
    idle("R8");

    step(1, 0, 12'h013, 32'h5A5A_5A5A, "R9");
    step(0, 1, 12'h010, 0, "R9");
    step(0, 1, 12'h102, 0, "R9");
    step(1, 0, 12'hF03, 32'd3, "R9");
    idle("R9");

    step(0, 1, 12'hF00, 32'd1, "R10");
    step(0, 1, 12'hF00, 32'd3, "R10");
    idle("R10");

    begin
      logic [31:0] lfsr = 32'h1ACE_B00C;
      for (int n = 0; n < 3000; n++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        step(lfsr[3], lfsr[4], {lfsr[5] & lfsr[6], 1'b0, lfsr[12:7], lfsr[16:13]},
             lfsr[17] ? {30'h0, lfsr[19:18]} : lfsr, "R2");
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule